// File: doc/BRIEF.md
# Bandwidth-quota round-robin DMA arbiter

This block shares one transfer resource among several DMA channels. Each channel has a byte quota. The channel that holds the grant keeps it while it still requests and has quota left. Every transfer acknowledgement reports a byte count, and that count is taken off the channel's remaining quota. The grant is released when the quota is spent or when the channel stops requesting. The next owner is found round-robin, starting at the channel after the one granted most recently. As a result, no channel can hold all of the resource's bandwidth.

Each channel can also run under external start/pause control. With the control enabled, a channel that spends its quota is paused. It is not granted again until a single-cycle start pulse for that channel restarts it. The block does not move any data. The transfer engine reports each completed beat through the acknowledge strobe and its byte count.

Top module: `bw_rr_arbiter`

## Requirements
- R1: After reset, no grant is asserted and no channel is paused.
- R2: At most one grant bit is high at a time. A grant goes only to a channel that was requesting and not paused in the previous cycle. The grant appears in the cycle after the request is seen.
- R3: The granted channel keeps the grant while it still requests and the bytes acknowledged since the grant are fewer than the quota sampled when the grant was given.
- R4: An acknowledgement that brings the acknowledged bytes to the quota or beyond releases the grant. In the next cycle the grant moves to the next eligible channel, which may be the same channel if it is the only one eligible.
- R5: The search for the next owner starts at the channel one above the one most recently granted, wraps from the highest index to channel 0, and skips channels that are not requesting or are paused.
- R6: If the owner drops its request before its quota is spent, the grant passes to the next eligible channel in the following cycle. If no channel is eligible, the grant drops to zero.
- R7: When a channel spends its quota while its external-control enable is high, it becomes paused in the next cycle. A paused channel is never granted.
- R8: A start pulse for a paused channel clears the pause in the next cycle, and the channel becomes eligible again. A start pulse for a channel that is not paused has no effect. A channel that spends its quota with its enable low is not paused.
- R9: An acknowledgement that arrives while no grant is held does not affect the quota of the next grant.
- R10: A quota of zero releases the grant at the first acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-channel transfer request |
| quota_i | input | NCH*QW | Per-channel byte quota; channel c occupies bits [c*QW +: QW] |
| ext_en_i | input | NCH | Per-channel enable for external start/pause control |
| ext_start_i | input | NCH | Per-channel single-cycle start pulse |
| ack_i | input | 1 | Transfer acknowledgement for the current owner |
| ack_bytes_i | input | BW | Bytes moved by the acknowledged transfer |
| gnt_o | output | NCH | One-hot grant |
| paused_o | output | NCH | Per-channel paused state |

## Verification
The bench builds the block with NCH=3, QW=8 and BW=8. With three channels the wrap of the round-robin search is non-power-of-two, and the rotation visits every channel, including skips over idle and paused ones. The byte widths allow acknowledgements that exactly spend a quota, acknowledgements that overshoot it, and a zero quota. Pause and restart are driven while other channels keep requesting, so it can be seen that a paused channel is bypassed and that it comes back after the start pulse.

// File: rtl/bwrr_pkg.sv
package bwrr_pkg;
  // a and n: a < 2*n
  function automatic int wrap_idx(int a, int n);
    return (a >= n) ? a - n : a;
  endfunction
endpackage

// File: rtl/bwrr_pick.sv
module bwrr_pick #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] elig_i,
  input  logic [IW-1:0]  start_i,
  output logic           found_o,
  output logic [IW-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // descending offset so the nearest candidate wins
    for (int k = NCH - 1; k >= 0; k--) begin
      int c;
      c = bwrr_pkg::wrap_idx(int'(start_i) + k, NCH);
      if (elig_i[c]) begin
        found_o = 1'b1;
        idx_o   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/bwrr_pause.sv
module bwrr_pause #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] start_i,
  output logic [NCH-1:0] paused_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         paused_o[g] <= 1'b0;
      else if (set_i[g])   paused_o[g] <= 1'b1;
      else if (start_i[g]) paused_o[g] <= 1'b0;
    end

    p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (paused_o[g] && start_i[g] && !set_i[g]) |=> !paused_o[g]);
  end
endmodule

// File: rtl/bw_rr_arbiter.sv
module bw_rr_arbiter #(
  parameter int NCH = 4,
  parameter int QW  = 12,
  parameter int BW  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic [NCH*QW-1:0] quota_i,
  input  logic [NCH-1:0]   ext_en_i,
  input  logic [NCH-1:0]   ext_start_i,
  input  logic             ack_i,
  input  logic [BW-1:0]    ack_bytes_i,
  output logic [NCH-1:0]   gnt_o,
  output logic [NCH-1:0]   paused_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW = ((QW > BW) ? QW : BW) + 2;

  logic                 own_vld_q;
  logic [IW-1:0]        own_q, last_q, start_idx, pick_idx;
  logic signed [CW-1:0] rem_q, rem_dec, ack_ext;
  logic                 pick_found, exhaust, release_own, arb_en;
  logic [NCH-1:0]       pause_set, elig;

  assign ack_ext     = {{(CW-BW){1'b0}}, ack_bytes_i};
  assign rem_dec     = rem_q - ack_ext;
  assign exhaust     = own_vld_q && ack_i && (rem_dec <= 0);
  assign release_own = own_vld_q && (exhaust || !req_i[own_q]);
  assign arb_en      = !own_vld_q || release_own;
  assign pause_set   = (exhaust && ext_en_i[own_q]) ? (NCH'(1) << own_q) : '0;
  assign elig        = req_i & ~paused_o & ~pause_set;
  assign start_idx   = (last_q == IW'(NCH - 1)) ? '0 : last_q + 1'b1;

  bwrr_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .elig_i  (elig),
    .start_i (start_idx),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  bwrr_pause #(.NCH(NCH)) u_pause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (pause_set),
    .start_i  (ext_start_i),
    .paused_o (paused_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      last_q    <= IW'(NCH - 1);
      rem_q     <= '0;
    end else if (arb_en) begin
      own_vld_q <= pick_found;
      if (pick_found) begin
        own_q  <= pick_idx;
        last_q <= pick_idx;
        rem_q  <= {{(CW-QW){1'b0}}, quota_i[int'(pick_idx)*QW +: QW]};
      end
    end else if (ack_i) begin
      rem_q <= rem_dec;
    end
  end

  assign gnt_o = own_vld_q ? (NCH'(1) << own_q) : '0;

  p_onehot_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_eligible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~($past(req_i) & ~$past(paused_o))) == '0);

  p_paused_not_gnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & paused_o) == '0);

  p_pause_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o & ~$past(paused_o) & ~$past(ext_en_i)) == '0);
endmodule

// File: tb/bw_rr_arbiter_tb.sv
module bw_rr_arbiter_tb;
  localparam int NCH = 3;
  localparam int QW  = 8;
  localparam int BW  = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0, ext_en = '0, ext_start = '0;
  logic [NCH*QW-1:0] quota = '0;
  logic ack = 1'b0;
  logic [BW-1:0] ack_bytes = '0;
  logic [NCH-1:0] gnt, paused;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_rr_arbiter #(.NCH(NCH), .QW(QW), .BW(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .quota_i(quota),
    .ext_en_i(ext_en), .ext_start_i(ext_start), .ack_i(ack),
    .ack_bytes_i(ack_bytes), .gnt_o(gnt), .paused_o(paused)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_ack(int bytes);
    ack = 1'b1; ack_bytes = BW'(bytes);
    step();
    ack = 1'b0; ack_bytes = '0;
  endtask

  task automatic set_quota(int c, int v);
    quota[c*QW +: QW] = QW'(v);
  endtask

  task automatic idle();
    req = '0; step(); step();
  endtask

  task automatic t_reset();
    chk("R1 gnt", gnt, '0);
    chk("R1 paused", paused, '0);
  endtask

  task automatic t_quota();
    req = 3'b101; step();
    chk("R2 first grant ch0", gnt, 3'b001);
    do_ack(4); chk("R3 hold ch0", gnt, 3'b001);
    do_ack(4); chk("R4 exact quota moves to ch2", gnt, 3'b100);
    chk("R8 no pause with enable low", paused, '0);
    do_ack(19); chk("R3 hold ch2", gnt, 3'b100);
    do_ack(1); chk("R4 back to ch0", gnt, 3'b001);
    req = '0; step();
    chk("R6 drop with no other requester", gnt, '0);
    step();
  endtask

  task automatic t_rotate();
    // last granted is ch0
    req = 3'b111; step();
    chk("R5 start after last", gnt, 3'b010);
    do_ack(7); chk("R5 overshoot rotates to ch2", gnt, 3'b100);
    do_ack(20); chk("R5 wrap to ch0", gnt, 3'b001);
    do_ack(8); chk("R5 to ch1", gnt, 3'b010);
    req = 3'b101; step();
    chk("R5 skip idle ch1 to ch2", gnt, 3'b100);
    do_ack(20); chk("R5 then ch0", gnt, 3'b001);
    idle();
  endtask

  task automatic t_drop();
    req = 3'b011; step();
    chk("R5 ch1 after ch0", gnt, 3'b010);
    do_ack(2); chk("R3 partial hold", gnt, 3'b010);
    req = 3'b001; step();
    chk("R6 drop moves to ch0", gnt, 3'b001);
    idle();
  endtask

  task automatic t_pause();
    ext_en = 3'b010;
    req = 3'b011; step();
    chk("R7 grant ch1", gnt, 3'b010);
    do_ack(5);
    chk("R7 paused ch1", paused, 3'b010);
    chk("R7 grant ch0", gnt, 3'b001);
    do_ack(8);
    chk("R7 paused skipped", gnt, 3'b001);
    chk("R7 still paused", paused, 3'b010);
    ext_start = 3'b010; step(); ext_start = '0;
    chk("R8 start clears pause", paused, '0);
    do_ack(8);
    chk("R8 restarted ch1 granted", gnt, 3'b010);
    ext_en = '0;
    idle();
    ext_start = 3'b100; step(); ext_start = '0;
    chk("R8 start while not paused ignored", paused, '0);
    chk("R8 no grant from start pulse", gnt, '0);
  endtask

  task automatic t_stray_ack();
    do_ack(3); do_ack(3);
    chk("R9 no grant from ack", gnt, '0);
    // last granted is ch1
    req = 3'b011; step();
    chk("R9 grant ch0", gnt, 3'b001);
    do_ack(7); chk("R9 full quota kept", gnt, 3'b001);
    do_ack(1); chk("R9 quota end to ch1", gnt, 3'b010);
    idle();
  endtask

  task automatic t_zero();
    set_quota(2, 0);
    req = 3'b101; step();
    chk("R10 grant ch2", gnt, 3'b100);
    do_ack(1); chk("R10 zero quota released", gnt, 3'b001);
    idle();
  endtask

  initial begin
    set_quota(0, 8); set_quota(1, 5); set_quota(2, 20);
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_quota();
    t_rotate();
    t_drop();
    t_pause();
    t_stray_ack();
    t_zero();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule